// File: doc/BRIEF.md
# Branch Target Interworking Unit

This block sits where a core turns a computed branch target into the next fetch address. It receives a request to write the program counter, together with the target and the kind of write. From these it works out the aligned address to fetch next and the instruction-set state. The state is a single mode bit: 0 selects the 32-bit instruction set and 1 selects the 16-bit compressed set. The block holds this mode bit in a register.

The low target bits do two jobs. They choose the instruction set for exchange-style writes, and they set how the address is aligned. The architecture version is an elaboration parameter. It decides whether writes from the ALU and from loads act as plain branches or as exchange branches. Combinations of target bits that have no defined meaning produce a one-cycle warning pulse. The address is still updated with a masked value when this happens.

Top module: `bti_unit`

## Requirements
- R1: A request (req_valid=1) is registered on the next rising clock edge. In the cycle after that edge, redirect is 1 and next_pc and t_bit show the resolved result. When no request is present, redirect returns to 0 and next_pc and t_bit keep their values. req_kind encodes the write type: 0 is a plain branch, 1 is an exchange branch, 2 is an ALU write, 3 is a load write.
- R2: While rst is high at a clock edge, next_pc, t_bit, redirect and unpredictable become 0.
- R3: An exchange write whose target bit 0 is 1 sets t_bit to 1. next_pc becomes the target with bit 0 cleared.
- R4: An exchange write whose target bits [1:0] are 00 clears t_bit. next_pc becomes the target unchanged.
- R5: An exchange write whose target bits [1:0] are 10 raises unpredictable and leaves t_bit unchanged. next_pc becomes the target with bits [1:0] cleared.
- R6: A plain write leaves t_bit unchanged. When t_bit is 0, next_pc is the target with bits [1:0] cleared. When t_bit is 1, next_pc is the target with only bit 0 cleared.
- R7: A plain write with t_bit 0 and nonzero target bits [1:0] raises unpredictable only when ARCH_VER is below 6.
- R8: An ALU write acts as an exchange write only when ARCH_VER is 7 or more and t_bit is 0. Otherwise it acts as a plain write.
- R9: A load write acts as an exchange write when ARCH_VER is 5 or more. Otherwise it acts as a plain write.
- R10: unpredictable is high for exactly the one cycle in which redirect reports the offending request. It is 0 in every cycle without a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A PC write request is present this cycle |
| req_kind | input | 2 | Write type: 0 plain, 1 exchange, 2 ALU, 3 load |
| req_target | input | ADDR_W | Computed branch target |
| next_pc | output | ADDR_W | Aligned next fetch address (registered) |
| redirect | output | 1 | One-cycle strobe: next_pc and t_bit were just updated |
| t_bit | output | 1 | Instruction-set mode: 0 is 32-bit, 1 is 16-bit |
| unpredictable | output | 1 | One-cycle pulse flagging an undefined target/mode combination |

## Verification
The assertions assume that req_kind and req_target are stable and fully defined whenever req_valid is high, and that reset is applied for at least one edge before the first request. The bench satisfies both conditions. It drives every input on the falling edge and holds reset for several cycles at the start. It sets the mode before each request with a known exchange write, so the mode-dependent rules are only exercised from a state the bench already knows. Three instances share the same stimulus at versions 4, 6 and 7, which keeps each version-gated rule inside its defined range.

// File: rtl/bti_pkg.sv
package bti_pkg;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_EXCH  = 2'd1,
    KIND_ALU   = 2'd2,
    KIND_LOAD  = 2'd3
  } bti_kind_e;

  // Classification of the two low target bits for an exchange write.
  typedef enum logic [1:0] {
    XCLS_TO_NARROW = 2'd0,
    XCLS_TO_WIDE   = 2'd1,
    XCLS_BAD       = 2'd2
  } bti_xcls_e;

  // Does this write take the mode-switching path?
  function automatic logic bti_use_exchange(input bti_kind_e kind,
                                            input int unsigned ver,
                                            input logic t_cur);
    logic r;
    unique case (kind)
      KIND_EXCH:  r = 1'b1;
      KIND_ALU:   r = (ver >= 7) && !t_cur;
      KIND_LOAD:  r = (ver >= 5);
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic bti_xcls_e bti_classify(input logic [1:0] low);
    bti_xcls_e c;
    if (low[0])       c = XCLS_TO_NARROW;
    else if (!low[1]) c = XCLS_TO_WIDE;
    else              c = XCLS_BAD;
    return c;
  endfunction

  // Plain writes in wide mode flag misalignment only on old versions.
  function automatic logic bti_plain_bad(input logic [1:0] low,
                                         input int unsigned ver,
                                         input logic t_cur);
    return !t_cur && (ver < 6) && (low != 2'b00);
  endfunction

endpackage

// File: rtl/bti_route.sv
module bti_route
  import bti_pkg::*;
#(
  parameter int unsigned ARCH_VER = 6
) (
  input  logic [1:0] kind,
  input  logic       t_cur,
  output logic       take_exchange
);
  always_comb begin
    take_exchange = bti_use_exchange(bti_kind_e'(kind), ARCH_VER, t_cur);
  end
endmodule

// File: rtl/bti_target.sv
module bti_target
  import bti_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ARCH_VER = 6
) (
  input  logic [ADDR_W-1:0] target,
  input  logic              t_cur,
  input  logic              take_exchange,
  output logic [ADDR_W-1:0] pc_out,
  output logic              t_out,
  output logic              bad_out
);
  localparam logic [ADDR_W-1:0] MASK_HALF = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] MASK_WORD = {{(ADDR_W-2){1'b1}}, 2'b00};

  bti_xcls_e xcls;

  always_comb begin
    xcls    = bti_classify(target[1:0]);
    pc_out  = target & MASK_WORD;
    t_out   = t_cur;
    bad_out = 1'b0;
    if (take_exchange) begin
      unique case (xcls)
        XCLS_TO_NARROW: begin
          pc_out = target & MASK_HALF;
          t_out  = 1'b1;
        end
        XCLS_TO_WIDE: begin
          pc_out = target;
          t_out  = 1'b0;
        end
        default: begin
          pc_out  = target & MASK_WORD;
          bad_out = 1'b1;
        end
      endcase
    end else if (t_cur) begin
      pc_out = target & MASK_HALF;
    end else begin
      pc_out  = target & MASK_WORD;
      bad_out = bti_plain_bad(target[1:0], ARCH_VER, t_cur);
    end
  end
endmodule

// File: rtl/bti_state.sv
module bti_state #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              t_in,
  input  logic              bad_in,
  output logic [ADDR_W-1:0] pc_q,
  output logic              t_q,
  output logic              strobe_q,
  output logic              bad_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      t_q      <= 1'b0;
      strobe_q <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      strobe_q <= load;
      bad_q    <= load & bad_in;
      if (load) begin
        pc_q <= pc_in;
        t_q  <= t_in;
      end
    end
  end
endmodule

// File: rtl/bti_unit.sv
module bti_unit #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ARCH_VER = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_target,
  output logic [ADDR_W-1:0] next_pc,
  output logic              redirect,
  output logic              t_bit,
  output logic              unpredictable
);
  // Named internal events, visible to the bound checker.
  logic              take_exchange;
  logic [ADDR_W-1:0] resolved_pc;
  logic              resolved_t;
  logic              req_unpred;

  bti_route #(.ARCH_VER(ARCH_VER)) route_i (
    .kind          (req_kind),
    .t_cur         (t_bit),
    .take_exchange (take_exchange)
  );

  bti_target #(.ADDR_W(ADDR_W), .ARCH_VER(ARCH_VER)) target_i (
    .target        (req_target),
    .t_cur         (t_bit),
    .take_exchange (take_exchange),
    .pc_out        (resolved_pc),
    .t_out         (resolved_t),
    .bad_out       (req_unpred)
  );

  bti_state #(.ADDR_W(ADDR_W)) state_i (
    .clk      (clk),
    .rst      (rst),
    .load     (req_valid),
    .pc_in    (resolved_pc),
    .t_in     (resolved_t),
    .bad_in   (req_unpred),
    .pc_q     (next_pc),
    .t_q      (t_bit),
    .strobe_q (redirect),
    .bad_q    (unpredictable)
  );
endmodule

// File: rtl/bti_unit_chk.sv
module bti_unit_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ARCH_VER = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [ADDR_W-1:0] req_target,
  input logic [ADDR_W-1:0] next_pc,
  input logic              redirect,
  input logic              t_bit,
  input logic              unpredictable,
  input logic              take_exchange,
  input logic              req_unpred
);
  AST_REQ_REDIRECTS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> redirect); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!redirect && $stable(next_pc) && $stable(t_bit))); // R1
  AST_EXCH_NARROW: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd1 && req_target[0]) |=> t_bit); // R3
  AST_EXCH_WIDE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd1 && req_target[1:0] == 2'b00) |=> !t_bit); // R4
  AST_EXCH_BAD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd1 && req_target[1:0] == 2'b10) |=> (unpredictable && $stable(t_bit))); // R5
  AST_PLAIN_KEEPS_T: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd0) |=> $stable(t_bit)); // R6
  AST_WIDE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (redirect && !t_bit) |-> (next_pc[1:0] == 2'b00)); // R6
  AST_NARROW_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (redirect && t_bit) |-> !next_pc[0]); // R6
  AST_LOAD_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd3) |-> (take_exchange == (ARCH_VER >= 5))); // R9
  AST_ALU_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd2 && t_bit) |-> !take_exchange); // R8
  AST_UNPRED_WITH_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    unpredictable |-> redirect); // R10
  AST_UNPRED_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_unpred) |=> unpredictable); // R10
  AST_UNPRED_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !unpredictable); // R10
endmodule

bind bti_unit bti_unit_chk #(.ADDR_W(ADDR_W), .ARCH_VER(ARCH_VER)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_kind      (req_kind),
  .req_target    (req_target),
  .next_pc       (next_pc),
  .redirect      (redirect),
  .t_bit         (t_bit),
  .unpredictable (unpredictable),
  .take_exchange (take_exchange),
  .req_unpred    (req_unpred)
);

// File: tb/bti_unit_tb_top.sv
module bti_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [AW-1:0] req_target = '0;

  logic [AW-1:0] pc7, pc6, pc4;
  logic rd7, rd6, rd4, t7, t6, t4, u7, u6, u4;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Shadow mode bit the bench keeps for each instance.
  bit mt7, mt6, mt4;

  always #(CLK_PERIOD/2) clk = ~clk;

  bti_unit #(.ADDR_W(AW), .ARCH_VER(7)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_target(req_target), .next_pc(pc7), .redirect(rd7), .t_bit(t7),
    .unpredictable(u7));
  bti_unit #(.ADDR_W(AW), .ARCH_VER(6)) dut_v6_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_target(req_target), .next_pc(pc6), .redirect(rd6), .t_bit(t6),
    .unpredictable(u6));
  bti_unit #(.ADDR_W(AW), .ARCH_VER(4)) dut_v4_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_target(req_target), .next_pc(pc4), .redirect(rd4), .t_bit(t4),
    .unpredictable(u4));

  task automatic check(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected result, restated from the requirements.
  function automatic void predict(input int ver, input bit tcur, input int kind,
                                  input logic [AW-1:0] tg, output logic [AW-1:0] pc,
                                  output bit tn, output bit un);
    bit xch;
    xch = (kind == 1) || (kind == 2 && ver >= 7 && tcur == 0) || (kind == 3 && ver >= 5);
    tn = tcur; un = 0;
    if (xch) begin
      case (tg[1:0])
        2'b01, 2'b11: begin pc = tg - 1; tn = 1; end
        2'b00:        begin pc = tg; tn = 0; end
        default:      begin pc = tg - 2; un = 1; end
      endcase
    end else if (tcur) begin
      pc = tg[0] ? tg - 1 : tg;
    end else begin
      pc = tg - AW'(tg[1:0]);
      un = (ver < 6) && (tg[1:0] != 0);
    end
  endfunction

  task automatic one_dut(input string req, input int ver, input bit tcur, input int kind,
                         input logic [AW-1:0] tg, input logic [AW-1:0] apc,
                         input logic ard, input logic at, input logic au, output bit tnew);
    logic [AW-1:0] epc; bit et, eu;
    predict(ver, tcur, kind, tg, epc, et, eu);
    check(req, $sformatf("v%0d pc", ver), apc, epc);
    check(req, $sformatf("v%0d t", ver), AW'(at), AW'(et));
    check(req, $sformatf("v%0d redirect", ver), AW'(ard), 1);
    check(req, $sformatf("v%0d unpred", ver), AW'(au), AW'(eu));
    tnew = et;
  endtask

  // Issue one request; check the cycle after the edge, then an idle cycle.
  task automatic do_req(input string req, input int kind, input logic [AW-1:0] tg);
    logic [AW-1:0] h7, h6, h4;
    bit n7, n6, n4;
    @(negedge clk);
    req_valid = 1; req_kind = 2'(kind); req_target = tg;
    @(negedge clk);
    req_valid = 0;
    one_dut(req, 7, mt7, kind, tg, pc7, rd7, t7, u7, n7);
    one_dut(req, 6, mt6, kind, tg, pc6, rd6, t6, u6, n6);
    one_dut(req, 4, mt4, kind, tg, pc4, rd4, t4, u4, n4);
    mt7 = n7; mt6 = n6; mt4 = n4;
    h7 = pc7; h6 = pc6; h4 = pc4;
    @(negedge clk);
    // R1 idle hold, R10 pulse ends
    check("R1", "idle redirect", AW'({rd7, rd6, rd4}), 0);
    check("R1", "idle pc hold", pc7 ^ h7 | pc6 ^ h6 | pc4 ^ h4, 0);
    check("R1", "idle t hold", AW'({t7, t6, t4}), AW'({mt7, mt6, mt4}));
    check("R10", "idle unpred", AW'({u7, u6, u4}), 0);
  endtask

  task automatic set_mode(input bit m);
    do_req("R3", 1, m ? 32'h0000_0101 : 32'h0000_0100);
  endtask

  task automatic sweep(input string req, input int kind);
    for (int m = 0; m < 2; m++) begin
      for (int lb = 0; lb < 4; lb++) begin
        set_mode(m[0]);
        do_req(req, kind, 32'h1234_5670 | 32'(lb) | (32'(lb) << 12));
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R2", "reset pc", pc7 | pc6 | pc4, 0);
    check("R2", "reset flags", AW'({t7, t6, t4, rd7, rd6, rd4, u7, u6, u4}), 0);
    mt7 = 0; mt6 = 0; mt4 = 0;
  endtask

  task automatic t_exchange(); sweep("R3_R4_R5", 1); endtask
  task automatic t_plain();    sweep("R6_R7", 0);    endtask
  task automatic t_alu();      sweep("R8", 2);       endtask
  task automatic t_load();     sweep("R9", 3);       endtask

  task automatic t_mid_reset();
    set_mode(1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R2", "mid reset t", AW'({t7, t6, t4}), 0);
    check("R2", "mid reset pc", pc7 | pc6 | pc4, 0);
    mt7 = 0; mt6 = 0; mt4 = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_exchange();
    t_plain();
    t_alu();
    t_load();
    t_mid_reset();
    t_exchange();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule